// File: doc/BRIEF.md
# Storage Card Host Register Block

This block is the software-visible register file of a storage-card host controller. A processor reaches it over a plain 32-bit bus: an address, a write strobe, a read strobe, write data and read data that follows the address in the same cycle. The block keeps the interrupt status and mask, the command argument, four response words, the transfer block length and block count, and a buffer address. It drives a single level interrupt line.

A write to the command offset does not execute anything here. It produces a one-cycle start pulse, with the written command word and the stored argument, toward a separate command engine. That engine hands back a 128-bit response, which it loads with a valid pulse, and status event pulses that set bits in the interrupt status. Data movement and the card-side signalling belong to other blocks.

The byte offsets are fixed, and the command engine and driver decode them: 0x00 status, 0x04 enable, 0x08 buffer address, 0x0C command, 0x10 argument, 0x14 to 0x20 response words 0 to 3, 0x24 block length, 0x28 block count, 0x2C card state. Status bit 0 flags command done, bit 1 flags data done, and bit 2 flags a card state change.

Top module: `card_host_regs`

## Requirements
- R1: A read of offset 0x00 returns the pending status ANDed with the enable mask in bits 2:0 and zero above. `irq` is high exactly when that masked value is nonzero.
- R2: A write to offset 0x00 clears every status bit whose written data bit is 1. All other status bits are kept.
- R3: A write to offset 0x04 loads bits 2:0 as the enable mask and discards all pending status.
- R4: An event pulse on `evt_in` sets its status bit at the next edge. If a status clear or an enable write arrives in the same cycle, the event still sets its bit.
- R5: A write to 0x24 sets `blk_len` to the written value plus one, and a write to 0x28 sets `blk_cnt` to the written value plus one. Both wrap modulo 2^32, so 0xFFFFFFFF gives 0.
- R6: A write to 0x0C raises `cmd_go` for exactly the one cycle after the write edge. During that cycle `cmd_code` carries the written word and `cmd_arg` carries the value last written to 0x10.
- R7: A `rsp_valid` pulse loads the four response words from `rsp_words`. Word i is bits 32i+31 to 32i. Reads of 0x14, 0x18, 0x1C and 0x20 return words 0 to 3.
- R8: A read of 0x2C returns 1 in bit 0 (card present), `card_ro` in bit 1, and zero in all other bits.
- R9: A read of any offset other than 0x00, 0x14 to 0x20 and 0x2C returns zero. This covers write-only registers, unmapped words and unaligned addresses. `bus_err` is then high for the one cycle after the read edge and low otherwise.
- R10: After reset, status, mask, `irq`, `cmd_go`, `bus_err`, response words, `blk_len`, `blk_cnt` and `buf_addr` are all zero.
- R11: A write to 0x08 places the written value on `buf_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 6 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| bus_err | output | 1 | One-cycle flag after a read of an undefined offset |
| irq | output | 1 | Level interrupt |
| cmd_go | output | 1 | One-cycle command start pulse |
| cmd_code | output | 32 | Command word written with the start |
| cmd_arg | output | 32 | Stored command argument |
| buf_addr | output | 32 | Buffer address register |
| blk_len | output | 32 | Block length (written value plus one) |
| blk_cnt | output | 32 | Block count (written value plus one) |
| rsp_valid | input | 1 | Loads the response words |
| rsp_words | input | 128 | Response from the command engine |
| evt_in | input | 3 | Status event pulses |
| card_ro | input | 1 | Card write-protect indication |

## Verification
The interrupt path is swept over all 512 combinations of enable mask, event pattern and clear pattern. Each combination checks the masked read and `irq` both before and after the clear. This separates a read that ignores the mask, a clear that inverts or ignores its data, and an interrupt that ignores the enable. Same-cycle collisions of an event with a clear and with an enable write show whether events have priority. A sweep over all offsets, plus unaligned ones, shows which reads return data and which raise the error. Boundary values 0 and 0xFFFFFFFF on length and count expose a missing increment or a missing wrap.

// File: rtl/card_host_pkg.sv
// Package: shared widths, word indices and the write-decode type for the
// card host register block. Word indices are byte offset divided by four;
// software and the command engine depend on this layout.
package card_host_pkg;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned NUM_STAT = 3;
    localparam int unsigned NUM_RSP  = 4;

    localparam int unsigned IDX_STAT  = 0;
    localparam int unsigned IDX_EN    = 1;
    localparam int unsigned IDX_BUF   = 2;
    localparam int unsigned IDX_CMD   = 3;
    localparam int unsigned IDX_ARG   = 4;
    localparam int unsigned IDX_RSP0  = 5;
    localparam int unsigned IDX_LEN   = 9;
    localparam int unsigned IDX_CNT   = 10;
    localparam int unsigned IDX_STATE = 11;

    typedef struct packed {
        logic stat_clr;
        logic en_ld;
        logic buf_ld;
        logic cmd_ld;
        logic arg_ld;
        logic len_ld;
        logic cnt_ld;
    } wr_dec_t;
endpackage

// File: rtl/card_host_wdec.sv
// Module: write address decoder. Turns a bus write into one load strike
// per writable register. Assumes word-aligned offsets; unaligned or
// unmapped writes strike nothing and are dropped.
module card_host_wdec
    import card_host_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output wr_dec_t           dec
);
    localparam int unsigned IW = ADDR_W - 2;

    logic [IW-1:0] idx;
    logic          ok;

    assign idx = addr[ADDR_W-1:2];
    assign ok  = wr && (addr[1:0] == 2'b00);

    // Purpose: one-hot style strikes for each writable word.
    always_comb begin
        dec          = '0;
        dec.stat_clr = ok && (idx == IW'(IDX_STAT));
        dec.en_ld    = ok && (idx == IW'(IDX_EN));
        dec.buf_ld   = ok && (idx == IW'(IDX_BUF));
        dec.cmd_ld   = ok && (idx == IW'(IDX_CMD));
        dec.arg_ld   = ok && (idx == IW'(IDX_ARG));
        dec.len_ld   = ok && (idx == IW'(IDX_LEN));
        dec.cnt_ld   = ok && (idx == IW'(IDX_CNT));
    end
endmodule

// File: rtl/card_host_status.sv
// Module: interrupt status and enable. Holds pending events, applies
// write-one-to-clear and enable loads, and forms the level interrupt.
// Assumes events are single-cycle pulses; an event always beats a clear.
module card_host_status #(
    parameter int unsigned NUM_STAT = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_wr,
    input  logic                en_wr,
    input  logic [NUM_STAT-1:0] wdata,
    input  logic [NUM_STAT-1:0] evt,
    output logic [NUM_STAT-1:0] stat_q,
    output logic [NUM_STAT-1:0] en_q,
    output logic [NUM_STAT-1:0] masked,
    output logic                irq
);
    logic [NUM_STAT-1:0] clr_mask;

    assign clr_mask = clr_wr ? wdata : '0;

    // Purpose: update pending status and mask; new events are ORed last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            en_q   <= '0;
        end else if (en_wr) begin
            en_q   <= wdata;
            stat_q <= evt;
        end else begin
            stat_q <= (stat_q & ~clr_mask) | evt;
        end
    end

    assign masked = stat_q & en_q;
    assign irq    = |masked;
endmodule

// File: rtl/card_host_rdmux.sv
// Module: read multiplexer. Returns the addressed word in the same cycle
// and registers a one-cycle error for reads of undefined offsets. Assumes
// only status, responses and card state are readable.
module card_host_rdmux
    import card_host_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         addr,
    input  logic                      rd,
    input  logic [NUM_STAT-1:0]       masked,
    input  logic [NUM_RSP*DATA_W-1:0] rsp_flat,
    input  logic                      card_ro,
    output logic [DATA_W-1:0]         rdata,
    output logic                      err
);
    localparam int unsigned IW = ADDR_W - 2;

    logic [IW-1:0] idx;
    logic          hit;

    assign idx = addr[ADDR_W-1:2];

    // Purpose: select the read word and flag whether the offset is defined.
    always_comb begin
        rdata = '0;
        hit   = 1'b0;
        if (addr[1:0] == 2'b00) begin
            if (idx == IW'(IDX_STAT)) begin
                rdata = DATA_W'(masked);
                hit   = 1'b1;
            end
            if (idx == IW'(IDX_STATE)) begin
                rdata = DATA_W'({card_ro, 1'b1});
                hit   = 1'b1;
            end
            for (int i = 0; i < int'(NUM_RSP); i++) begin
                if (idx == IW'(IDX_RSP0 + i)) begin
                    rdata = rsp_flat[i*DATA_W +: DATA_W];
                    hit   = 1'b1;
                end
            end
        end
    end

    // Purpose: one-cycle error after a read that hit nothing.
    always_ff @(posedge clk) begin
        if (!rst_n) err <= 1'b0;
        else        err <= rd && !hit;
    end
endmodule

// File: rtl/card_host_regs.sv
// Module: top of the card host register block. Holds the plain data
// registers and the response words, issues the command start pulse, and
// ties the write decoder, status unit and read mux together. Assumes the
// bus never writes and reads the same cycle it expects both to act.
module card_host_regs
    import card_host_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    output logic                      bus_err,
    output logic                      irq,
    output logic                      cmd_go,
    output logic [DATA_W-1:0]         cmd_code,
    output logic [DATA_W-1:0]         cmd_arg,
    output logic [DATA_W-1:0]         buf_addr,
    output logic [DATA_W-1:0]         blk_len,
    output logic [DATA_W-1:0]         blk_cnt,
    input  logic                      rsp_valid,
    input  logic [NUM_RSP*DATA_W-1:0] rsp_words,
    input  logic [NUM_STAT-1:0]       evt_in,
    input  logic                      card_ro
);
    wr_dec_t                   dec;
    logic [NUM_STAT-1:0]       stat_q;
    logic [NUM_STAT-1:0]       en_q;
    logic [NUM_STAT-1:0]       masked;
    logic [NUM_RSP*DATA_W-1:0] rsp_q;

    card_host_wdec #(.ADDR_W(ADDR_W)) u_wdec (
        .addr (bus_addr),
        .wr   (bus_wr),
        .dec  (dec)
    );

    card_host_status #(.NUM_STAT(NUM_STAT)) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_wr (dec.stat_clr),
        .en_wr  (dec.en_ld),
        .wdata  (bus_wdata[NUM_STAT-1:0]),
        .evt    (evt_in),
        .stat_q (stat_q),
        .en_q   (en_q),
        .masked (masked),
        .irq    (irq)
    );

    card_host_rdmux #(.ADDR_W(ADDR_W)) u_rdmux (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .rd       (bus_rd),
        .masked   (masked),
        .rsp_flat (rsp_q),
        .card_ro  (card_ro),
        .rdata    (bus_rdata),
        .err      (bus_err)
    );

    // Purpose: plain data registers; length and count hold value plus one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_addr <= '0;
            cmd_arg  <= '0;
            blk_len  <= '0;
            blk_cnt  <= '0;
        end else begin
            if (dec.buf_ld) buf_addr <= bus_wdata;
            if (dec.arg_ld) cmd_arg  <= bus_wdata;
            if (dec.len_ld) blk_len  <= bus_wdata + DATA_W'(1);
            if (dec.cnt_ld) blk_cnt  <= bus_wdata + DATA_W'(1);
        end
    end

    // Purpose: one-cycle start pulse carrying the written command word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_go   <= 1'b0;
            cmd_code <= '0;
        end else begin
            cmd_go <= dec.cmd_ld;
            if (dec.cmd_ld) cmd_code <= bus_wdata;
        end
    end

    // Purpose: one register per response word, loaded together.
    for (genvar g = 0; g < int'(NUM_RSP); g++) begin : g_rsp
        always_ff @(posedge clk) begin
            if (!rst_n)         rsp_q[g*DATA_W +: DATA_W] <= '0;
            else if (rsp_valid) rsp_q[g*DATA_W +: DATA_W] <= rsp_words[g*DATA_W +: DATA_W];
        end
    end
endmodule

// File: rtl/card_host_regs_chk.sv
// Module: assertion checker bound to card_host_regs. Observes the bus,
// outputs and the pending status and mask; drives nothing.
module card_host_regs_chk
    import card_host_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_wr,
    input logic                bus_rd,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic                bus_err,
    input logic                irq,
    input logic                cmd_go,
    input logic [DATA_W-1:0]   cmd_code,
    input logic [DATA_W-1:0]   blk_len,
    input logic [NUM_STAT-1:0] evt_in,
    input logic [NUM_STAT-1:0] stat_q
);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(IDX_STAT * 4);
    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(IDX_EN * 4);
    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(IDX_CMD * 4);
    localparam logic [ADDR_W-1:0] A_LEN  = ADDR_W'(IDX_LEN * 4);

    AST_IRQ_MATCHES_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_STAT) |-> (irq == (bus_rdata != '0))); // R1

    AST_EN_WRITE_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_wr && bus_addr == A_EN) |-> (stat_q == $past(evt_in))); // R3

    AST_EVENT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(evt_in) != '0) |-> (($past(evt_in) & ~stat_q) == '0)); // R4

    AST_LEN_PLUS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_wr && bus_addr == A_LEN) |-> (blk_len == $past(bus_wdata) + DATA_W'(1))); // R5

    AST_CMD_PULSE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_go |-> $past(bus_wr && bus_addr == A_CMD)); // R6

    AST_CMD_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_go |-> (cmd_code == $past(bus_wdata))); // R6

    AST_UNALIGNED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr[1:0] != 2'b00) |-> (bus_rdata == '0)); // R9

    AST_ERR_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_rd)); // R9
endmodule

bind card_host_regs card_host_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_err   (bus_err),
    .irq       (irq),
    .cmd_go    (cmd_go),
    .cmd_code  (cmd_code),
    .blk_len   (blk_len),
    .evt_in    (evt_in),
    .stat_q    (stat_q)
);

// File: tb/card_host_regs_bench.sv
`timescale 1ns/1ps
// Bench: drives the register block from tasks at the falling edge and
// compares against values worked out from the requirements.
module card_host_regs_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [5:0]   bus_addr = '0;
    logic         bus_wr = 1'b0;
    logic         bus_rd = 1'b0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         bus_err;
    logic         irq;
    logic         cmd_go;
    logic [31:0]  cmd_code;
    logic [31:0]  cmd_arg;
    logic [31:0]  buf_addr;
    logic [31:0]  blk_len;
    logic [31:0]  blk_cnt;
    logic         rsp_valid = 1'b0;
    logic [127:0] rsp_words = '0;
    logic [2:0]   evt_in = '0;
    logic         card_ro = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    card_host_regs u_card_host_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .irq(irq), .cmd_go(cmd_go), .cmd_code(cmd_code),
        .cmd_arg(cmd_arg), .buf_addr(buf_addr), .blk_len(blk_len),
        .blk_cnt(blk_cnt), .rsp_valid(rsp_valid), .rsp_words(rsp_words),
        .evt_in(evt_in), .card_ro(card_ro)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d, output logic e);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
        e = bus_err;
    endtask

    task automatic pulse(input logic [2:0] e);
        @(negedge clk);
        evt_in = e;
        @(negedge clk);
        evt_in = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic        e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        rd(6'h00, d, e);
        chk("R10 status", d, 0);
        chk("R10 irq", {31'b0, irq}, 0);
        chk("R10 cmd_go", {31'b0, cmd_go}, 0);
        chk("R10 blk_len", blk_len, 0);
        chk("R10 blk_cnt", blk_cnt, 0);
        chk("R10 buf_addr", buf_addr, 0);
        for (int i = 0; i < 4; i++) begin
            rd(6'(8'h14 + 4*i), d, e);
            chk("R10 response", d, 0);
        end

        // R1 R2 R3: sweep mask x event x clear
        for (int m = 0; m < 8; m++) begin
            for (int ev = 0; ev < 8; ev++) begin
                for (int c = 0; c < 8; c++) begin
                    wr(6'h04, 32'(m));
                    pulse(3'(ev));
                    rd(6'h00, d, e);
                    chk("R1 masked read", d, 32'(ev & m));
                    chk("R1 irq level", {31'b0, irq}, 32'((ev & m) != 0));
                    wr(6'h00, 32'(c));
                    rd(6'h00, d, e);
                    chk("R2 w1c read", d, 32'(ev & ~c & m));
                    chk("R2 irq after clear", {31'b0, irq}, 32'((ev & ~c & m) != 0));
                end
            end
        end

        // R3: enable write discards pending status
        wr(6'h04, 32'h7);
        pulse(3'h7);
        wr(6'h04, 32'h7);
        rd(6'h00, d, e);
        chk("R3 enable wipes status", d, 0);
        chk("R3 irq low", {31'b0, irq}, 0);

        // R4: event beats a same-cycle clear
        pulse(3'h7);
        @(negedge clk);
        bus_addr = 6'h00; bus_wdata = 32'h7; bus_wr = 1'b1; evt_in = 3'b001;
        @(negedge clk);
        bus_wr = 1'b0; evt_in = '0;
        rd(6'h00, d, e);
        chk("R4 event over clear", d, 32'h1);
        // R4: event beats a same-cycle enable write
        @(negedge clk);
        bus_addr = 6'h04; bus_wdata = 32'h7; bus_wr = 1'b1; evt_in = 3'b010;
        @(negedge clk);
        bus_wr = 1'b0; evt_in = '0;
        rd(6'h00, d, e);
        chk("R4 event over enable write", d, 32'h2);

        // R5: plus one with wrap
        wr(6'h24, 32'h0);
        chk("R5 len 0", blk_len, 32'h1);
        wr(6'h24, 32'h1FF);
        chk("R5 len 511", blk_len, 32'h200);
        wr(6'h24, 32'hFFFF_FFFF);
        chk("R5 len wrap", blk_len, 32'h0);
        wr(6'h28, 32'h0);
        chk("R5 cnt 0", blk_cnt, 32'h1);
        wr(6'h28, 32'h7);
        chk("R5 cnt 7", blk_cnt, 32'h8);
        wr(6'h28, 32'hFFFF_FFFF);
        chk("R5 cnt wrap", blk_cnt, 32'h0);

        // R6: command pulse with stored argument
        wr(6'h10, 32'hA5A5_0001);
        wr(6'h0C, 32'h0000_0011);
        chk("R6 cmd_go high", {31'b0, cmd_go}, 1);
        chk("R6 cmd_code", cmd_code, 32'h11);
        chk("R6 cmd_arg", cmd_arg, 32'hA5A5_0001);
        @(negedge clk);
        chk("R6 cmd_go one cycle", {31'b0, cmd_go}, 0);

        // R11: buffer address
        wr(6'h08, 32'h8000_1000);
        chk("R11 buf_addr", buf_addr, 32'h8000_1000);

        // R7: response words
        @(negedge clk);
        rsp_words = {32'h3333_0003, 32'h2222_0002, 32'h1111_0001, 32'h0000_F000};
        rsp_valid = 1'b1;
        @(negedge clk);
        rsp_valid = 1'b0;
        rsp_words = '1;
        for (int i = 0; i < 4; i++) begin
            logic [31:0] exp_w;
            exp_w = (i == 0) ? 32'h0000_F000 : (32'h1111_0000 * i + 32'(i));
            rd(6'(8'h14 + 4*i), d, e);
            chk("R7 response word", d, exp_w);
            chk("R7 no error", {31'b0, e}, 0);
        end

        // R8: card state
        card_ro = 1'b0;
        rd(6'h2C, d, e);
        chk("R8 writable card", d, 32'h1);
        card_ro = 1'b1;
        rd(6'h2C, d, e);
        chk("R8 read-only card", d, 32'h3);

        // R9: every aligned offset and some unaligned ones
        for (int w = 0; w < 16; w++) begin
            bit defined;
            defined = (w == 0) || (w >= 5 && w <= 8) || (w == 11);
            rd(6'(w * 4), d, e);
            chk("R9 error flag", {31'b0, e}, 32'(!defined));
            if (!defined) chk("R9 read zero", d, 0);
            @(negedge clk);
            chk("R9 error one cycle", {31'b0, bus_err}, 0);
        end
        rd(6'h15, d, e);
        chk("R9 unaligned zero", d, 0);
        chk("R9 unaligned error", {31'b0, e}, 1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule